// File: doc/BRIEF.md
# Dual-Encoding Serial Clock Prescaler

This block turns the system clock into the timing strobes of a serial shift engine. The divisor between the two clocks comes from a small prescale field inside a wider configuration word. A build-time parameter picks one of two encodings for that field. The compact encoding gives even ratios from 4 to 30. The wide encoding multiplies a 4-bit mantissa by a power of two and gives ratios from 1 to 1920.

The block has no clock output of its own. It gives the shift engine a level that shows the serial-clock phase, a pulse at each leading edge and each trailing edge, and an end-of-period tick. The engine marks a transfer by holding its busy input high. While that input is low, the block clears its phase counter and takes the decoded divisor from the configuration word. While the input is high, the divisor it holds stays fixed, so every transfer starts with a fresh, aligned period.

Top module: `spi_clk_prescaler`

## Requirements
- R1: With the compact encoding, bits 4:0 form a code equal to 16 + divisor/2. Codes 0x12 through 0x1F give the even divisors 4 through 30, and the serial clock period equals the divisor in system clocks.
- R2: With the compact encoding, any code below 0x12 gives a divisor of 4.
- R3: With the wide encoding, bits 3:0 hold a mantissa. Bit 4 holds exponent bit 0 and bits 7:6 hold exponent bits 2:1. The divisor is mantissa × 2^exponent, which ranges from 1 to 1920.
- R4: With the wide encoding, a mantissa of zero acts as a mantissa of one.
- R5: Configuration bits outside the prescale field have no effect on the divisor. For the compact encoding these are bits 15:5. For the wide encoding these are bit 5 and bits 15:8.
- R6: During a transfer, the phase level is high for ceil(d/2) cycles and then low for floor(d/2) cycles of each d-cycle period. While idle, the phase level is low.
- R7: The leading-edge pulse marks the first cycle of each period. The trailing-edge pulse marks the first low cycle, and it never occurs when d = 1. The tick marks the last cycle of each period, so when d = 1 it fires every cycle.
- R8: A change to the configuration word while busy is high leaves the running transfer unchanged. The new value applies from the next transfer.
- R9: The first busy cycle of every transfer is the start of a period: the leading-edge pulse is high and the phase level is high.
- R10: While reset is asserted and while idle, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 16 | Configuration word that holds the prescale field |
| engine_busy | input | 1 | High while the shift engine runs a transfer |
| sclk_o | output | 1 | Serial clock phase level |
| lead_edge_o | output | 1 | Pulse in the first cycle of each period |
| trail_edge_o | output | 1 | Pulse in the first low-phase cycle of a period |
| tick_o | output | 1 | Pulse in the last cycle of each period |

## Verification
The bench builds two copies of the block side by side: one with the compact encoding and one with the wide encoding. Both copies get the same configuration word and the same busy signal. The compact copy covers the clamp region and every even ratio. The wide copy covers the ratio-of-one case, odd ratios with uneven phases, each exponent bit on its own, and the full 1920 limit. Every transfer is checked cycle by cycle against a waveform model computed by the bench.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

    typedef enum logic {
        ENC_LEGACY   = 1'b0,
        ENC_EXTENDED = 1'b1
    } presc_enc_e;

    localparam int CFG_W        = 16;
    localparam int MANT_W       = 4;
    localparam int EXP_W        = 3;
    localparam int DIV_W        = MANT_W + (1 << EXP_W) - 1;
    localparam int EXT_MAX_DIV  = ((1 << MANT_W) - 1) * (1 << ((1 << EXP_W) - 1));
    localparam int LEG_BASE     = 16;
    localparam int LEG_MIN_CODE = 18;
    localparam int LEG_MIN_DIV  = 4;
    localparam int LEG_MAX_DIV  = 30;
    localparam logic [CFG_W-1:0] LEG_MASK = CFG_W'(16'h001F);
    localparam logic [CFG_W-1:0] EXT_MASK = CFG_W'(16'h00DF);

    typedef logic [CFG_W-1:0] cfg_t;
    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic [EXP_W-1:0]  expo;
    } ext_field_t;

    typedef struct packed {
        logic sclk;
        logic lead;
        logic trail;
        logic tick;
    } clk_evt_t;

    function automatic ext_field_t split_ext(cfg_t w);
        ext_field_t x;
        x.mant = w[MANT_W-1:0];
        x.expo = {w[7:6], w[4]};
        return x;
    endfunction

    function automatic div_t ext_div(ext_field_t x);
        logic [MANT_W-1:0] m;
        m = (x.mant == '0) ? MANT_W'(1) : x.mant;
        return div_t'(m) << x.expo;
    endfunction

    function automatic div_t legacy_div(cfg_t w);
        int code;
        code = int'(w[4:0]);
        if (code < LEG_MIN_CODE)
            return div_t'(LEG_MIN_DIV);
        return div_t'((code - LEG_BASE) * 2);
    endfunction

endpackage

// File: rtl/spi_presc_decode.sv
module spi_presc_decode
    import spi_presc_pkg::*;
#(
    parameter presc_enc_e ENC = ENC_LEGACY
) (
    input  cfg_t cfg_word,
    output div_t div_o
);
    localparam cfg_t FIELD_MASK = (ENC == ENC_EXTENDED) ? EXT_MASK : LEG_MASK;

    cfg_t field;
    assign field = cfg_word & FIELD_MASK;

    generate
        if (ENC == ENC_EXTENDED) begin : g_ext
            assign div_o = ext_div(split_ext(field));
        end else begin : g_leg
            assign div_o = legacy_div(field);
        end
    endgenerate

endmodule

// File: rtl/spi_presc_counter.sv
module spi_presc_counter
    import spi_presc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     busy,
    input  div_t     div_new,
    output clk_evt_t evt_o
);
    div_t div_q;
    div_t cnt_q;
    div_t half;
    div_t last;
    logic run;

    assign run  = busy && !rst;
    assign half = (div_q >> 1) + div_t'(div_q[0]);
    assign last = div_q - div_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= div_t'(1);
            cnt_q <= '0;
        end else if (!busy) begin
            div_q <= div_new;
            cnt_q <= '0;
        end else begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + div_t'(1);
        end
    end

    always_comb begin
        evt_o.sclk  = run && (cnt_q < half);
        evt_o.lead  = run && (cnt_q == '0);
        evt_o.trail = run && (div_q != div_t'(1)) && (cnt_q == half);
        evt_o.tick  = run && (cnt_q == last);
    end

    // R8
    div_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(div_q));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (evt_o.lead && evt_o.sclk));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_o.tick && busy) |=> (!busy || evt_o.lead));

    // R7
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(evt_o.lead && evt_o.trail));

    // R6
    fall_chk: assert property (@(posedge clk) disable iff (rst)
        evt_o.trail |-> (!evt_o.sclk && $past(evt_o.sclk)));

endmodule

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler
    import spi_presc_pkg::*;
#(
    parameter presc_enc_e ENC = ENC_LEGACY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             engine_busy,
    output logic             sclk_o,
    output logic             lead_edge_o,
    output logic             trail_edge_o,
    output logic             tick_o
);
    div_t     dec_div;
    clk_evt_t evt;

    spi_presc_decode #(.ENC(ENC)) u_decode (
        .cfg_word (cfg_word),
        .div_o    (dec_div)
    );

    spi_presc_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .busy    (engine_busy),
        .div_new (dec_div),
        .evt_o   (evt)
    );

    assign sclk_o       = evt.sclk;
    assign lead_edge_o  = evt.lead;
    assign trail_edge_o = evt.trail;
    assign tick_o       = evt.tick;

    generate
        if (ENC == ENC_LEGACY) begin : g_leg_chk
            // R1
            leg_div_range_chk: assert property (@(posedge clk) disable iff (rst)
                (dec_div >= div_t'(LEG_MIN_DIV)) && (dec_div <= div_t'(LEG_MAX_DIV)) && !dec_div[0]);
        end else begin : g_ext_chk
            // R3
            ext_div_range_chk: assert property (@(posedge clk) disable iff (rst)
                (dec_div != '0) && (dec_div <= div_t'(EXT_MAX_DIV)));
        end
    endgenerate

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !engine_busy |-> !(sclk_o || lead_edge_o || trail_edge_o || tick_o));

endmodule

// File: tb/spi_clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module spi_clk_prescaler_tb_top;
    import spi_presc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_word = 16'h0000;
    logic        engine_busy = 1'b0;
    logic [3:0]  leg_o;
    logic [3:0]  ext_o;
    int          checks = 0;
    int          fails = 0;

    always #2.5 clk = ~clk;

    spi_clk_prescaler #(.ENC(ENC_EXTENDED)) dut_i (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .engine_busy(engine_busy),
        .sclk_o(ext_o[3]), .lead_edge_o(ext_o[2]), .trail_edge_o(ext_o[1]), .tick_o(ext_o[0])
    );

    spi_clk_prescaler #(.ENC(ENC_LEGACY)) dut_leg_i (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .engine_busy(engine_busy),
        .sclk_o(leg_o[3]), .lead_edge_o(leg_o[2]), .trail_edge_o(leg_o[1]), .tick_o(leg_o[0])
    );

    function automatic int exp_leg(logic [15:0] c);
        int f;
        f = int'(c[4:0]);
        return (f < 18) ? 4 : 2 * (f - 16);
    endfunction

    function automatic int exp_ext(logic [15:0] c);
        int m;
        int e;
        m = int'(c[3:0]);
        if (m == 0) m = 1;
        e = int'({c[7:6], c[4]});
        return m << e;
    endfunction

    function automatic logic [3:0] model(int d, int k);
        int c;
        int h;
        c = k % d;
        h = (d + 1) / 2;
        return {c < h, c == 0, (d > 1) && (c == h), c == d - 1};
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check(string tag, string what, logic ok, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got %b expected %b", tag, what, got, exp);
        end
    endtask

    task automatic xfer(string tag, logic [15:0] c1, logic [15:0] c2);
        int dl;
        int de;
        int n;
        int bad_l;
        int bad_e;
        logic [3:0] gl;
        logic [3:0] el;
        logic [3:0] ge;
        logic [3:0] ee;
        dl = exp_leg(c1);
        de = exp_ext(c1);
        n = 2 * ((dl > de) ? dl : de);
        bad_l = 0;
        bad_e = 0;
        gl = '0; el = '0; ge = '0; ee = '0;
        cfg_word = c1;
        engine_busy = 1'b0;
        repeat (2) @(negedge clk);
        engine_busy = 1'b1;
        for (int k = 0; k < n; k++) begin
            #1;
            if (bad_l == 0 && leg_o !== model(dl, k)) begin
                bad_l = 1; gl = leg_o; el = model(dl, k);
            end
            if (bad_e == 0 && ext_o !== model(de, k)) begin
                bad_e = 1; ge = ext_o; ee = model(de, k);
            end
            if (k == 0) cfg_word = c2;
            @(negedge clk);
        end
        engine_busy = 1'b0;
        check(tag, $sformatf("compact cfg=%h div=%0d", c1, dl), bad_l == 0, gl, el);
        check(tag, $sformatf("wide cfg=%h div=%0d", c1, de), bad_e == 0, ge, ee);
        #1;
        check("R10", "idle outputs after transfer", (leg_o | ext_o) == 4'b0, leg_o | ext_o, 4'b0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, all requirements unfinished");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        #1;
        check("R10", "outputs during reset", (leg_o | ext_o) == 4'b0, leg_o | ext_o, 4'b0);
        engine_busy = 1'b1;
        #1;
        check("R10", "busy held under reset", (leg_o | ext_o) == 4'b0, leg_o | ext_o, 4'b0);
        engine_busy = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R10", "idle after reset", (leg_o | ext_o) == 4'b0, leg_o | ext_o, 4'b0);
        @(negedge clk);

        // R1: every compact code in range
        for (int f = 18; f < 32; f++) xfer("R1", 16'(f), 16'(f));
        // R2: clamp region
        xfer("R2", 16'h0000, 16'h0000);
        xfer("R2", 16'h0011, 16'h0011);
        // R3: exponent bits one at a time, limits
        xfer("R3", 16'h0013, 16'h0013);
        xfer("R3", 16'h0043, 16'h0043);
        xfer("R3", 16'h0083, 16'h0083);
        xfer("R3", 16'h00D5, 16'h00D5);
        xfer("R3", 16'h00DF, 16'h00DF);
        // R4: zero mantissa
        xfer("R4", 16'h0050, 16'h0050);
        // R7: divisor one, every-cycle tick, no trailing pulse
        xfer("R7", 16'h0001, 16'h0001);
        // R6: odd divisors give uneven phases
        xfer("R6", 16'h0007, 16'h0007);
        xfer("R6", 16'h000F, 16'h000F);
        // R5: bits outside the field set
        xfer("R5", 16'hAB23, 16'hAB23);
        xfer("R5", 16'hFF3A, 16'hFF3A);
        // R8: mid-transfer change ignored, then applied
        xfer("R8", 16'h0017, 16'h001F);
        xfer("R8", 16'h001F, 16'h001F);
        // R9: back-to-back transfers restart aligned
        xfer("R9", 16'h0015, 16'h0015);
        // random mix
        for (int i = 0; i < 16; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            xfer("R3", r, r);
        end
        report();
        $finish;
    end

endmodule